// File: doc/BRIEF.md
# Six-Channel Converter Limit Comparator Bank

This block watches six converter result channels. Each channel compares a 12-bit sample with its own upper and lower thresholds. For each channel, a configuration bit picks the sample source: the raw conversion result or the averaged result. A comparison runs only on that channel's result-valid strobe.

Each comparison updates two live flags per channel. These live flags always show the outcome of the latest comparison. The same comparison can also set two sticky flags, which stay set until software reads the sticky status word. One read of that word returns all twelve sticky flags and clears every one of them. An enable mask selects which sticky flags drive the single interrupt line. The mask has no effect on whether a flag latches.

Software reaches thresholds, source selects, enables and both flag words through a small register port. The port has a write strobe, a read strobe, one address and registered read data.

Top module: `limit_mon_bank`

## Requirements
- R1: Channel c compares the averaged sample when bit c of the source-select register (address 16) is 1, and the raw sample when it is 0.
- R2: A channel's upper flag is computed as 1 when its unsigned 12-bit sample is greater than or equal to its high limit (address c).
- R3: A channel's lower flag is computed as 1 when its unsigned 12-bit sample is less than or equal to its low limit (address 8+c).
- R4: The live flag word (address 18: bit c is the upper flag of channel c, bit 6+c is its lower flag) changes only on that channel's strobe, and otherwise holds the latest outcome even when the sample inputs change.
- R5: A sticky flag, packed like the live word at address 19, is set by a strobe whose comparison trips it and stays set until the sticky word is read.
- R6: A read of address 19 returns the sticky word on the following cycle and clears all twelve sticky flags. A read of any other address leaves them unchanged.
- R7: A trip on the same cycle as a clearing read remains set after the read.
- R8: Sticky flags latch whatever the value of the interrupt enable register (address 17, packed like the live word).
- R9: The interrupt output is 1 exactly when some sticky flag and its enable bit are both 1.
- R10: After reset, limits, source selects, enables, live flags, sticky flags, read data and the interrupt output are all zero.
- R11: Addresses 0-5, 8-13, 16 and 17 read back their last written values on the cycle after the read strobe. Unmapped addresses read zero, and writes to addresses 18 and 19 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_data | input | 72 | Raw samples, channel c in bits [12c+11:12c] |
| avg_data | input | 72 | Averaged samples, same packing |
| res_valid | input | 6 | Per-channel result-valid strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 12 | Write data |
| rdata | output | 12 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Enabled sticky flag present |

## Verification
The bench uses the default parameters: six channels and 12-bit samples. This size lets it sweep every channel through a stepped range of samples plus each threshold boundary (limit minus one, the limit, limit plus one). Odd channels compare the averaged source, while the unselected source carries a mirrored value. A wrong source pick therefore shows up as a wrong flag. With twelve flags, the whole enable mask and the whole flag word are each checked as a single word, and the bench drives a read and a trip together to check that the trip survives the clear.

// File: rtl/limit_mon_pkg.sv
package limit_mon_pkg;
  // Register map (word addresses)
  localparam int ADDR_HI_BASE = 0;
  localparam int ADDR_LO_BASE = 8;
  localparam int ADDR_SRC_SEL = 16;
  localparam int ADDR_IRQ_EN  = 17;
  localparam int ADDR_LIVE    = 18;
  localparam int ADDR_STICKY  = 19;

  // Upper threshold reached: sample at or above the limit
  function automatic logic reaches_high(input logic [31:0] sample, input logic [31:0] lim);
    return sample >= lim;
  endfunction

  // Lower threshold reached: sample at or below the limit
  function automatic logic reaches_low(input logic [31:0] sample, input logic [31:0] lim);
    return sample <= lim;
  endfunction
endpackage

// File: rtl/limit_mon_cfg.sv
module limit_mon_cfg
  import limit_mon_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 5,
  parameter int REG_W  = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [NUM_CH-1:0][DATA_W-1:0] hi_lim,
  output logic [NUM_CH-1:0][DATA_W-1:0] lo_lim,
  output logic [NUM_CH-1:0]             src_avg,
  output logic [2*NUM_CH-1:0]           irq_en
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lim
    logic hi_hit, lo_hit;
    assign hi_hit = wr_en && (addr == ADDR_W'(ADDR_HI_BASE + c));
    assign lo_hit = wr_en && (addr == ADDR_W'(ADDR_LO_BASE + c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_lim[c] <= '0;
        lo_lim[c] <= '0;
      end else begin
        if (hi_hit) hi_lim[c] <= wdata[DATA_W-1:0];
        if (lo_hit) lo_lim[c] <= wdata[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_avg <= '0;
      irq_en  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADDR_SRC_SEL)) src_avg <= wdata[NUM_CH-1:0];
      if (addr == ADDR_W'(ADDR_IRQ_EN))  irq_en  <= wdata[2*NUM_CH-1:0];
    end
  end
endmodule

// File: rtl/limit_mon_chan.sv
module limit_mon_chan
  import limit_mon_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] raw_smp,
  input  logic [DATA_W-1:0] avg_smp,
  input  logic              use_avg,
  input  logic              strobe,
  input  logic [DATA_W-1:0] hi_lim,
  input  logic [DATA_W-1:0] lo_lim,
  output logic              trip_up,
  output logic              trip_lo,
  output logic              live_up,
  output logic              live_lo
);
  logic [DATA_W-1:0] smp;
  logic cmp_up, cmp_lo;

  assign smp     = use_avg ? avg_smp : raw_smp;
  assign cmp_up  = reaches_high(32'(smp), 32'(hi_lim));
  assign cmp_lo  = reaches_low(32'(smp), 32'(lo_lim));
  assign trip_up = strobe & cmp_up;
  assign trip_lo = strobe & cmp_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_up <= 1'b0;
      live_lo <= 1'b0;
    end else if (strobe) begin
      live_up <= cmp_up;
      live_lo <= cmp_lo;
    end
  end
endmodule

// File: rtl/limit_mon_status.sv
module limit_mon_status
  import limit_mon_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 5,
  parameter int REG_W  = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [2*NUM_CH-1:0]           trip_vec,
  input  logic [2*NUM_CH-1:0]           live_vec,
  input  logic [NUM_CH-1:0][DATA_W-1:0] hi_lim,
  input  logic [NUM_CH-1:0][DATA_W-1:0] lo_lim,
  input  logic [NUM_CH-1:0]             src_avg,
  input  logic [2*NUM_CH-1:0]           irq_en,
  output logic [2*NUM_CH-1:0]           sticky_vec,
  output logic                          clr_pulse,
  output logic [REG_W-1:0]              rdata,
  output logic                          irq
);
  localparam int FLAG_W = 2 * NUM_CH;

  logic [REG_W-1:0] rd_mux;

  assign clr_pulse = rd_en && (addr == ADDR_W'(ADDR_STICKY));

  // New trips win over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_vec <= '0;
    else        sticky_vec <= (sticky_vec & ~{FLAG_W{clr_pulse}}) | trip_vec;
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(ADDR_HI_BASE + c)) rd_mux = REG_W'(hi_lim[c]);
      if (addr == ADDR_W'(ADDR_LO_BASE + c)) rd_mux = REG_W'(lo_lim[c]);
    end
    if (addr == ADDR_W'(ADDR_SRC_SEL)) rd_mux = REG_W'(src_avg);
    if (addr == ADDR_W'(ADDR_IRQ_EN))  rd_mux = REG_W'(irq_en);
    if (addr == ADDR_W'(ADDR_LIVE))    rd_mux = REG_W'(live_vec);
    if (addr == ADDR_W'(ADDR_STICKY))  rd_mux = REG_W'(sticky_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign irq = |(sticky_vec & irq_en);
endmodule

// File: rtl/limit_mon_bank.sv
module limit_mon_bank
  import limit_mon_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 5,
  localparam int REG_W = (DATA_W > 2 * NUM_CH) ? DATA_W : 2 * NUM_CH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*DATA_W-1:0] raw_data,
  input  logic [NUM_CH*DATA_W-1:0] avg_data,
  input  logic [NUM_CH-1:0]        res_valid,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [REG_W-1:0]         wdata,
  output logic [REG_W-1:0]         rdata,
  output logic                     irq
);
  logic [NUM_CH-1:0][DATA_W-1:0] hi_lim, lo_lim;
  logic [NUM_CH-1:0]             src_avg;
  logic [2*NUM_CH-1:0]           irq_en;
  logic [2*NUM_CH-1:0]           trip_vec;
  logic [2*NUM_CH-1:0]           live_vec;
  logic [2*NUM_CH-1:0]           sticky_vec;
  logic                          clr_pulse;

  limit_mon_cfg #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .src_avg(src_avg), .irq_en(irq_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    limit_mon_chan #(.DATA_W(DATA_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_smp (raw_data[c*DATA_W +: DATA_W]),
      .avg_smp (avg_data[c*DATA_W +: DATA_W]),
      .use_avg (src_avg[c]),
      .strobe  (res_valid[c]),
      .hi_lim  (hi_lim[c]),
      .lo_lim  (lo_lim[c]),
      .trip_up (trip_vec[c]),
      .trip_lo (trip_vec[NUM_CH+c]),
      .live_up (live_vec[c]),
      .live_lo (live_vec[NUM_CH+c])
    );
  end

  limit_mon_status #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .trip_vec(trip_vec), .live_vec(live_vec),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .src_avg(src_avg), .irq_en(irq_en),
    .sticky_vec(sticky_vec), .clr_pulse(clr_pulse), .rdata(rdata), .irq(irq)
  );
endmodule

// File: rtl/limit_mon_bank_chk.sv
module limit_mon_bank_chk #(
  parameter int NUM_CH = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   res_valid,
  input logic [2*NUM_CH-1:0] trip_vec,
  input logic [2*NUM_CH-1:0] live_vec,
  input logic [2*NUM_CH-1:0] sticky_vec,
  input logic                clr_pulse,
  input logic                irq
);
  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid == '0) |=> $stable(live_vec)) else $error("live flags moved without strobe"); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_pulse && trip_vec == '0) |=> $stable(sticky_vec)) else $error("sticky moved"); // R5

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && trip_vec == '0) |=> (sticky_vec == '0)) else $error("sticky not cleared"); // R6

  AST_TRIP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_vec != '0) |=> ((sticky_vec & $past(trip_vec)) == $past(trip_vec))) else $error("trip lost"); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_vec == '0) |-> !irq) else $error("irq without flag"); // R9
endmodule

bind limit_mon_bank limit_mon_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .trip_vec(trip_vec),
  .live_vec(live_vec), .sticky_vec(sticky_vec), .clr_pulse(clr_pulse), .irq(irq)
);

// File: tb/limit_mon_bank_test.sv
module limit_mon_bank_test;
  localparam int NCH = 6;
  localparam int DW  = 12;
  localparam int AW  = 5;
  localparam int RW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH*DW-1:0] raw_data = '0, avg_data = '0;
  logic [NCH-1:0] res_valid = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rdata;
  logic irq;

  int checks = 0;
  int errors = 0;

  int hi_v [NCH];
  int lo_v [NCH];
  logic [2*NCH-1:0] exp_live = '0;
  logic [2*NCH-1:0] exp_sticky = '0;
  logic [NCH-1:0] sel_avg = 6'b101010;

  always #5 clk = ~clk;

  limit_mon_bank uut (
    .clk(clk), .rst_n(rst_n), .raw_data(raw_data), .avg_data(avg_data),
    .res_valid(res_valid), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, want);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = RW'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [RW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // Present value v on the selected source of channel c, mirrored on the other
  task automatic strobe(input int c, input int v);
    @(negedge clk);
    if (sel_avg[c]) begin
      avg_data[c*DW +: DW] = DW'(v);
      raw_data[c*DW +: DW] = DW'(4095 - v);
    end else begin
      raw_data[c*DW +: DW] = DW'(v);
      avg_data[c*DW +: DW] = DW'(4095 - v);
    end
    res_valid[c] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_valid = '0;
  endtask

  function automatic logic up_ok(int v, int h);
    return !(v < h);
  endfunction

  function automatic logic low_ok(int v, int l);
    return (l - v) >= 0;
  endfunction

  task automatic apply(input int c, input int v);
    logic u, l;
    u = up_ok(v, hi_v[c]);
    l = low_ok(v, lo_v[c]);
    strobe(c, v);
    exp_live[c] = u;
    exp_live[NCH+c] = l;
    if (u) exp_sticky[c] = 1'b1;
    if (l) exp_sticky[NCH+c] = 1'b1;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RW-1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 irq", irq, 0);
    check("R10 rdata", rdata, 0);
    rd(0, d);  check("R10 hi0", d, 0);
    rd(8, d);  check("R10 lo0", d, 0);
    rd(16, d); check("R10 sel", d, 0);
    rd(17, d); check("R10 ien", d, 0);
    rd(18, d); check("R10 live", d, 0);
    rd(19, d); check("R10 sticky", d, 0);

    // R11 register readback
    for (int c = 0; c < NCH; c++) begin
      hi_v[c] = 'h900 - c * 'h40;
      lo_v[c] = 'h300 + c * 'h20;
      wr(c, hi_v[c]);
      wr(8 + c, lo_v[c]);
    end
    wr(16, sel_avg);
    wr(18, 'hfff);
    wr(19, 'hfff);
    for (int c = 0; c < NCH; c++) begin
      rd(c, d);     check("R11 hi readback", d, hi_v[c]);
      rd(8 + c, d); check("R11 lo readback", d, lo_v[c]);
    end
    rd(16, d); check("R11 sel readback", d, sel_avg);
    rd(18, d); check("R11 live write ignored", d, 0);
    rd(19, d); check("R11 sticky write ignored", d, 0);
    rd(7, d);  check("R11 unmapped", d, 0);
    rd(25, d); check("R11 unmapped", d, 0);

    // R1 R2 R3 R4 R5 sweep of every channel
    for (int c = 0; c < NCH; c++) begin
      for (int v = 0; v < 4096; v += 131) begin
        apply(c, v);
        rd(18, d); check("R1/R2/R3/R4 live sweep", d, exp_live);
      end
      for (int k = -1; k <= 1; k++) begin
        apply(c, hi_v[c] + k);
        rd(18, d); check("R2 high boundary", d, exp_live);
        apply(c, lo_v[c] + k);
        rd(18, d); check("R3 low boundary", d, exp_live);
      end
      apply(c, 4095);
      rd(18, d); check("R2 full scale", d, exp_live);
      // R5 sticky accumulated, R6 clearing read
      rd(19, d); check("R5 sticky word", d, exp_sticky);
      exp_sticky = '0;
      rd(19, d); check("R6 sticky cleared", d, 0);
    end

    // R4 hold: inputs change with no strobe
    raw_data = '1; avg_data = '0;
    repeat (3) @(posedge clk);
    rd(18, d); check("R4 hold without strobe", d, exp_live);

    // R8 latch with enables off, R9 interrupt mask
    apply(0, 4000);
    check("R8 irq masked", irq, 0);
    rd(17, d); rd(18, d);
    rd(19, d); check("R8 latched with enables off", d, exp_sticky);
    rd(19, d); check("R6 clear", d, 0);
    exp_sticky = '0;
    apply(0, 4000);
    wr(17, 1 << NCH);
    check("R9 other enable only", irq, 0);
    wr(17, 1);
    check("R9 enabled flag", irq, 1);
    rd(17, d); check("R11 ien readback", d, 1);
    wr(17, 'hfff);
    rd(5, d); check("R6 other read keeps sticky", irq, 1);
    rd(19, d); check("R9 read returns flag", d, exp_sticky);
    exp_sticky = '0;
    check("R9 irq drops after clear", irq, 0);

    // R7 trip concurrent with clearing read
    apply(3, 0);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(19);
    raw_data[2*DW +: DW] = DW'(4095);
    avg_data[2*DW +: DW] = DW'(4095);
    res_valid[2] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; res_valid = '0;
    check("R7 read returns earlier sticky", rdata, exp_sticky);
    check("R7 irq from kept trip", irq, 1);
    rd(19, d); check("R7 trip kept", d, 1 << 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule